// File: doc/BRIEF.md
# PS/2 Two-Way Line Sniffer

This block listens to the clock and data lines of a PS/2 keyboard or mouse link and never drives them. A fast system clock oversamples both lines. Each line passes through a two-stage synchroniser and a short glitch filter, and then through an edge detector. A frame controller uses the resulting edges to find frame starts and to decide which side is sending. It gathers the eleven bits of each frame and reports the byte with its direction, its parity status and its stop-bit status.

When the host sends a frame, the device answers with an acknowledge, and the block reports that acknowledge as a separate pulse. The sampling clock edge can be chosen separately for each direction, so a capture can be matched to where each side actually changes its data. A frame that stalls with the clock line held high is dropped after a set number of system clocks, and the block then waits for a fresh start.

Top module: `ps2_bus_sniffer`

## Requirements
- R1: A frame carries a start bit, eight data bits with the least significant bit first, a parity bit and a stop bit. When the stop bit is sampled, `valid` pulses high for exactly one cycle and `data` holds the byte, where the first data bit after the start bit is `data[0]`. Consecutive frames are each reported once.
- R2: `parity_err` is 0 when the eight data bits and the parity bit together hold an odd number of ones. It is 1 when they hold an even number.
- R3: `frame_err` is 1 when the stop bit is sampled as 0, and 0 when it is sampled as 1.
- R4: While no bit has been collected, a start sample of 1 is thrown away. It produces no `valid`, and it does not shift the bits of the next frame.
- R5: A clock fall from idle that comes together with a data edge starts a host-to-device frame, reported with `dir`=1. A clock fall from idle with no data edge starts a device-to-host frame, reported with `dir`=0.
- R6: For host-to-device frames, `cfg_h2d_fall`=0 samples bits on clock rises and 1 samples them on clock falls. For device-to-host frames, `cfg_d2h_rise`=0 samples bits on clock falls and 1 samples them on clock rises. Both inputs may change only while the bus is idle.
- R7: After the last bit of a host-to-device frame, the block waits for a clock rise and then for a data rise. At that data rise, `ack_seen` pulses for one cycle. No `ack_seen` ever follows a device-to-host frame.
- R8: When the filtered clock line stays high with no edge for `IDLE_LIMIT` system clocks, any partly collected frame is dropped. The next frame then decodes correctly.
- R9: A change on either line that lasts fewer than `FILT_LEN` system clocks is ignored.
- R10: While `rst` is held and in the first cycle after it is released, `valid`, `ack_seen`, `data`, `dir`, `parity_err` and `frame_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_in | input | 1 | Observed bus clock line |
| ps2_dat_in | input | 1 | Observed bus data line |
| cfg_h2d_fall | input | 1 | Host-to-device sampling edge: 0 rise, 1 fall |
| cfg_d2h_rise | input | 1 | Device-to-host sampling edge: 0 fall, 1 rise |
| valid | output | 1 | One-cycle strobe when a frame completes |
| data | output | 8 | Decoded byte |
| dir | output | 1 | 1 host-to-device, 0 device-to-host |
| parity_err | output | 1 | Parity check failed for the frame |
| frame_err | output | 1 | Stop bit was sampled as 0 |
| ack_seen | output | 1 | One-cycle pulse on device acknowledge |

## Verification
The hardest case to reach from the ports is a frame sampled on the wrong clock edge. If data stays stable across a whole bus-clock period, a design that uses the wrong edge still decodes the right byte. To expose it, the stimulus drives the true bit only during the half-period that leads up to the selected sampling edge, and drives its complement during the other half. A wrong edge choice therefore corrupts the byte. Random frames mix this with random directions, edge settings, parity and stop corruption, and missing acknowledges. Directed cases add a short clock glitch inside a frame, a rejected high start sample, and a frame abandoned partway so that the idle timeout must clear it.

// File: rtl/ps2snf_pkg.sv
package ps2snf_pkg;

  typedef enum logic [2:0] {
    SNF_IDLE    = 3'd0,
    SNF_H2D     = 3'd1,
    SNF_D2H     = 3'd2,
    SNF_ACK_CLK = 3'd3,
    SNF_ACK_DAT = 3'd4
  } snf_state_t;

  // Index of the line inside the conditioned-line arrays.
  localparam int LINE_CLK = 0;
  localparam int LINE_DAT = 1;
  localparam int NUM_LINES = 2;

endpackage

// File: rtl/ps2snf_line_cond.sv
module ps2snf_line_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic [CW-1:0]          stab_cnt;
  logic                   filt_q;
  logic                   prev_q;

  // Lines idle high on an open-collector bus.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
  end
  assign synced = sync_q[SYNC_STAGES-1];

  // The filtered level follows only after FILT_LEN agreeing samples.
  always_ff @(posedge clk) begin
    if (rst) begin
      stab_cnt <= '0;
      filt_q   <= 1'b1;
      prev_q   <= 1'b1;
    end else begin
      prev_q <= filt_q;
      if (synced == filt_q) begin
        stab_cnt <= '0;
      end else if (stab_cnt == CW'(FILT_LEN - 1)) begin
        stab_cnt <= '0;
        filt_q   <= synced;
      end else begin
        stab_cnt <= stab_cnt + 1'b1;
      end
    end
  end

  assign lvl  = filt_q;
  assign rise = filt_q & ~prev_q;
  assign fall = ~filt_q & prev_q;

endmodule

// File: rtl/ps2snf_idle_timer.sv
module ps2snf_idle_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_lvl,
  input  logic clk_edge,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !clk_lvl || clk_edge) cnt <= '0;
    else if (cnt != CW'(LIMIT))       cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(LIMIT));

endmodule

// File: rtl/ps2snf_frame.sv
module ps2snf_frame
  import ps2snf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              c_rise,
  input  logic              c_fall,
  input  logic              d_rise,
  input  logic              d_fall,
  input  logic              d_lvl,
  input  logic              cfg_h2d_fall,
  input  logic              cfg_d2h_rise,
  input  logic              expired,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              dir,
  output logic              parity_err,
  output logic              frame_err,
  output logic              ack_seen,
  output logic [2:0]        state_o,
  output logic [$clog2(DATA_W+3)-1:0] bit_cnt_o
);
  localparam int LAST  = DATA_W + 2;          // index of the stop bit
  localparam int SH_W  = DATA_W + 2;          // data, parity, stop
  localparam int CNT_W = $clog2(LAST + 1);

  snf_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [SH_W-1:0]   shreg;
  logic [SH_W-1:0]   shifted;
  logic              smp;

  assign shifted = {d_lvl, shreg[SH_W-1:1]};

  always_comb begin
    if (state == SNF_H2D) smp = cfg_h2d_fall ? c_fall : c_rise;
    else                  smp = cfg_d2h_rise ? c_rise : c_fall;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SNF_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      valid      <= 1'b0;
      data       <= '0;
      dir        <= 1'b0;
      parity_err <= 1'b0;
      frame_err  <= 1'b0;
      ack_seen   <= 1'b0;
    end else begin
      valid    <= 1'b0;
      ack_seen <= 1'b0;
      if (expired && state != SNF_IDLE) begin
        state <= SNF_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          SNF_IDLE: begin
            if (c_fall) begin
              cnt <= '0;
              if (d_rise || d_fall) begin
                state <= SNF_H2D;
              end else if (cfg_d2h_rise) begin
                state <= SNF_D2H;
              end else if (!d_lvl) begin
                state <= SNF_D2H;
                cnt   <= CNT_W'(1);
              end
            end
          end
          SNF_H2D, SNF_D2H: begin
            if (smp) begin
              if (cnt == '0) begin
                if (d_lvl) state <= SNF_IDLE;
                else       cnt   <= CNT_W'(1);
              end else begin
                shreg <= shifted;
                if (cnt == CNT_W'(LAST)) begin
                  valid      <= 1'b1;
                  data       <= shifted[DATA_W-1:0];
                  parity_err <= ~(^shifted[DATA_W:0]);
                  frame_err  <= ~d_lvl;
                  dir        <= (state == SNF_H2D);
                  cnt        <= '0;
                  state      <= (state == SNF_H2D) ? SNF_ACK_CLK : SNF_IDLE;
                end else begin
                  cnt <= cnt + 1'b1;
                end
              end
            end
          end
          SNF_ACK_CLK: if (c_rise) state <= SNF_ACK_DAT;
          SNF_ACK_DAT: begin
            if (d_rise) begin
              ack_seen <= 1'b1;
              state    <= SNF_IDLE;
            end
          end
          default: state <= SNF_IDLE;
        endcase
      end
    end
  end

  assign state_o   = state;
  assign bit_cnt_o = cnt;

endmodule

// File: rtl/ps2_bus_sniffer.sv
module ps2_bus_sniffer
  import ps2snf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  parameter int IDLE_LIMIT  = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ps2_clk_in,
  input  logic              ps2_dat_in,
  input  logic              cfg_h2d_fall,
  input  logic              cfg_d2h_rise,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              dir,
  output logic              parity_err,
  output logic              frame_err,
  output logic              ack_seen
);
  localparam int CNT_W = $clog2(DATA_W + 3);

  logic [NUM_LINES-1:0] raw_in;
  logic [NUM_LINES-1:0] lvl;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] fall;
  logic                 expired;
  logic [2:0]           fsm_state;
  logic [CNT_W-1:0]     bit_cnt;

  assign raw_in[LINE_CLK] = ps2_clk_in;
  assign raw_in[LINE_DAT] = ps2_dat_in;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    ps2snf_line_cond #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_LEN    (FILT_LEN)
    ) u_cond (
      .clk     (clk),
      .rst     (rst),
      .line_in (raw_in[g]),
      .lvl     (lvl[g]),
      .rise    (rise[g]),
      .fall    (fall[g])
    );
  end

  ps2snf_idle_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clk_lvl  (lvl[LINE_CLK]),
    .clk_edge (rise[LINE_CLK] | fall[LINE_CLK]),
    .expired  (expired)
  );

  ps2snf_frame #(.DATA_W(DATA_W)) u_frame (
    .clk          (clk),
    .rst          (rst),
    .c_rise       (rise[LINE_CLK]),
    .c_fall       (fall[LINE_CLK]),
    .d_rise       (rise[LINE_DAT]),
    .d_fall       (fall[LINE_DAT]),
    .d_lvl        (lvl[LINE_DAT]),
    .cfg_h2d_fall (cfg_h2d_fall),
    .cfg_d2h_rise (cfg_d2h_rise),
    .expired      (expired),
    .valid        (valid),
    .data         (data),
    .dir          (dir),
    .parity_err   (parity_err),
    .frame_err    (frame_err),
    .ack_seen     (ack_seen),
    .state_o      (fsm_state),
    .bit_cnt_o    (bit_cnt)
  );

endmodule

// File: rtl/ps2_bus_sniffer_chk.sv
module ps2_bus_sniffer_chk #(
  parameter int CNT_W = 4,
  parameter int LAST  = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             valid,
  input logic             ack_seen,
  input logic             dir,
  input logic [2:0]       fsm_state,
  input logic [CNT_W-1:0] bit_cnt
);
  import ps2snf_pkg::*;

  assert_valid_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(LAST));

  assert_idle_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == SNF_IDLE) |-> (bit_cnt == '0));

  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    ack_seen |=> !ack_seen);

  assert_ack_h2d_only_R7: assert property (@(posedge clk) disable iff (rst)
    ack_seen |-> dir);

  assert_ack_not_with_valid_R7: assert property (@(posedge clk) disable iff (rst)
    !(valid && ack_seen));

  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid && !ack_seen && !dir));

endmodule

bind ps2_bus_sniffer ps2_bus_sniffer_chk #(
  .CNT_W ($clog2(DATA_W + 3)),
  .LAST  (DATA_W + 2)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .valid     (valid),
  .ack_seen  (ack_seen),
  .dir       (dir),
  .fsm_state (fsm_state),
  .bit_cnt   (bit_cnt)
);

// File: tb/sim_ps2_bus_sniffer.sv
module sim_ps2_bus_sniffer;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 20;     // system clocks per bus half-period
  localparam int IDLE_LIM   = 1000;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pclk = 1'b1;
  logic       pdat = 1'b1;
  logic       cfg_h2d_fall = 1'b0;
  logic       cfg_d2h_rise = 1'b0;
  logic       valid, dir, parity_err, frame_err, ack_seen;
  logic [7:0] data;

  int tests = 0;
  int fails = 0;
  int vcount = 0;
  int acount = 0;
  logic [7:0] last_data;
  logic       last_dir, last_perr, last_ferr;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_bus_sniffer #(.IDLE_LIMIT(IDLE_LIM)) u0 (
    .clk          (clk),
    .rst          (rst),
    .ps2_clk_in   (pclk),
    .ps2_dat_in   (pdat),
    .cfg_h2d_fall (cfg_h2d_fall),
    .cfg_d2h_rise (cfg_d2h_rise),
    .valid        (valid),
    .data         (data),
    .dir          (dir),
    .parity_err   (parity_err),
    .frame_err    (frame_err),
    .ack_seen     (ack_seen)
  );

  always @(negedge clk) begin
    if (!rst && valid) begin
      vcount++;
      last_data = data;
      last_dir  = dir;
      last_perr = parity_err;
      last_ferr = frame_err;
    end
    if (!rst && ack_seen) acount++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [10:0] frame_bits(input logic [7:0] b, input bit bad_par,
                                             input bit bad_stop);
    logic [10:0] f;
    f[0]   = 1'b0;
    f[8:1] = b;
    f[9]   = (~^b) ^ bad_par;
    f[10]  = ~bad_stop;
    return f;
  endfunction

  // The true bit is present only in the half-period ending at the chosen edge.
  task automatic d2h_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop,
                           input int nbits, input int glitch_bit);
    logic [10:0] f = frame_bits(b, bad_par, bad_stop);
    for (int i = 0; i < nbits; i++) begin
      wait_n(H/2);
      pdat = cfg_d2h_rise ? ~f[i] : f[i];
      if (i == glitch_bit) begin
        wait_n(2); pclk = 1'b0; wait_n(1); pclk = 1'b1; wait_n(H/2 - 3);
      end else begin
        wait_n(H/2);
      end
      pclk = 1'b0;
      wait_n(H/2);
      pdat = cfg_d2h_rise ? f[i] : ~f[i];
      wait_n(H/2);
      pclk = 1'b1;
    end
    wait_n(H/2);
    pdat = 1'b1;
    wait_n(H);
  endtask

  task automatic h2d_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop,
                           input bit do_ack);
    logic [10:0] f = frame_bits(b, bad_par, bad_stop);
    wait_n(H);
    pclk = 1'b0; pdat = 1'b0;
    for (int i = 0; i < 11; i++) begin
      wait_n(H/2);
      pdat = cfg_h2d_fall ? ~f[i] : f[i];
      wait_n(H/2);
      pclk = 1'b1;
      wait_n(H/2);
      pdat = cfg_h2d_fall ? f[i] : ~f[i];
      wait_n(H/2);
      pclk = 1'b0;
    end
    if (do_ack) begin
      wait_n(H/2); pdat = 1'b0;
      wait_n(H/2); pclk = 1'b1;
      wait_n(H/2); pdat = 1'b1;
      wait_n(H);
    end else begin
      wait_n(H/2); pdat = 1'b1;
      wait_n(H/2); pclk = 1'b1;
      wait_n(IDLE_LIM + 100);
    end
  endtask

  task automatic expect_frame(input int vc0, input logic [7:0] b, input bit d,
                              input bit perr, input bit ferr, input string req);
    @(negedge clk);
    chk(vcount == vc0 + 1, {req, " R1 one strobe"}, vcount - vc0, 1);
    chk(last_data == b, {req, " R1 byte"}, last_data, b);
    chk(last_dir == d, {req, " R5 dir"}, last_dir, d);
    chk(last_perr == perr, {req, " R2 parity"}, last_perr, perr);
    chk(last_ferr == ferr, {req, " R3 stop"}, last_ferr, ferr);
  endtask

  initial begin : watchdog
    wait_n(WATCHDOG);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int vc0, ac0, seed;
    seed = $urandom(32'd4242);
    wait_n(5);
    @(negedge clk);
    // R10: outputs quiet while held in reset
    chk({valid, ack_seen, dir, parity_err, frame_err, data} == 13'd0, "R10 in reset",
        {valid, ack_seen, dir, parity_err, frame_err, data}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({valid, ack_seen, data} == 10'd0, "R10 after release", {valid, ack_seen, data}, 0);
    wait_n(20);

    // R1 R5 basic device-to-host
    vc0 = vcount; ac0 = acount;
    d2h_frame(8'hA5, 0, 0, 11, -1);
    expect_frame(vc0, 8'hA5, 0, 0, 0, "d2h A5");
    chk(acount == ac0, "R7 no ack after d2h", acount - ac0, 0);

    // R5 R7 host-to-device with acknowledge
    vc0 = vcount; ac0 = acount;
    h2d_frame(8'h3C, 0, 0, 1);
    expect_frame(vc0, 8'h3C, 1, 0, 0, "h2d 3C");
    chk(acount == ac0 + 1, "R7 ack seen", acount - ac0, 1);

    // R2 extremes and a corrupted parity bit
    vc0 = vcount; d2h_frame(8'h00, 0, 0, 11, -1); expect_frame(vc0, 8'h00, 0, 0, 0, "d2h 00");
    vc0 = vcount; d2h_frame(8'hFF, 0, 0, 11, -1); expect_frame(vc0, 8'hFF, 0, 0, 0, "d2h FF");
    vc0 = vcount; d2h_frame(8'h81, 1, 0, 11, -1); expect_frame(vc0, 8'h81, 0, 1, 0, "R2 bad parity");

    // R3 stop sampled low
    vc0 = vcount; h2d_frame(8'h6E, 0, 1, 1); expect_frame(vc0, 8'h6E, 1, 0, 1, "R3 bad stop");

    // R4 high start sample is dropped, next frame intact
    vc0 = vcount;
    wait_n(H); pclk = 1'b0; wait_n(H); pclk = 1'b1; wait_n(H);
    @(negedge clk);
    chk(vcount == vc0, "R4 no strobe on high start", vcount - vc0, 0);
    d2h_frame(8'h5A, 0, 0, 11, -1);
    expect_frame(vc0, 8'h5A, 0, 0, 0, "R4 following frame");

    // R9 short clock glitch inside a frame
    vc0 = vcount; d2h_frame(8'hC6, 0, 0, 11, 4); expect_frame(vc0, 8'hC6, 0, 0, 0, "R9 glitch");

    // R8 partial frame abandoned by the idle timeout
    vc0 = vcount;
    d2h_frame(8'h12, 0, 0, 5, -1);
    wait_n(IDLE_LIM + 50);
    d2h_frame(8'hC3, 0, 0, 11, -1);
    expect_frame(vc0, 8'hC3, 0, 0, 0, "R8 timeout");

    // R6 alternate sampling edges in both directions
    cfg_d2h_rise = 1'b1; cfg_h2d_fall = 1'b1; wait_n(H);
    vc0 = vcount; d2h_frame(8'h96, 0, 0, 11, -1); expect_frame(vc0, 8'h96, 0, 0, 0, "R6 d2h rise");
    vc0 = vcount; ac0 = acount;
    h2d_frame(8'h4B, 0, 0, 1);
    expect_frame(vc0, 8'h4B, 1, 0, 0, "R6 h2d fall");
    chk(acount == ac0 + 1, "R7 ack with fall sampling", acount - ac0, 1);
    cfg_d2h_rise = 1'b0; cfg_h2d_fall = 1'b0; wait_n(H);

    // Random mix
    for (int n = 0; n < 30; n++) begin
      logic [7:0] b;
      bit h2d, bp, bs, ak;
      b  = 8'($urandom);
      h2d = 1'($urandom);
      bp = ($urandom % 5) == 0;
      bs = ($urandom % 6) == 0;
      ak = ($urandom % 5) != 0;
      cfg_h2d_fall = 1'($urandom);
      cfg_d2h_rise = 1'($urandom);
      wait_n(H);
      vc0 = vcount; ac0 = acount;
      if (h2d) h2d_frame(b, bp, bs, ak);
      else     d2h_frame(b, bp, bs, 11, -1);
      expect_frame(vc0, b, h2d, bp, bs, "random R1 R6");
      chk(acount == ac0 + ((h2d && ak) ? 1 : 0), "R7 random ack", acount - ac0,
          (h2d && ak) ? 1 : 0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule